// File: doc/BRIEF.md
# Triple-Bit Self-Shrinking Selector

This block thins a serial bit stream. Bits arrive one per accepted beat over a valid/ready handshake and are grouped into back-to-back triples that do not overlap. Once the last bit of a triple is accepted, the block XORs the two leading bits of that triple. If the XOR is 1, the trailing bit is emitted on the output with a one-cycle strobe. If the XOR is 0, the whole triple is dropped without a trace.

The source of the stream, usually a shift-register sequence generator, sits outside the block. The output stream is irregular and shorter than the input: on average about one bit in six survives. A synchronous flush realigns the grouping so that a new stream starts on a triple boundary. While flush is high, no input beat is taken.

Top module: `tsg_selector`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `out_valid_o` is 0 and the next accepted bit is the first bit of a new triple.
- R2: A beat is accepted only when `in_valid_i` and `in_ready_o` are both high. Cycles without an accepted beat do not move the position within the current triple.
- R3: When the XOR of the first and second accepted bits of a triple is 1, `out_valid_o` is high in the cycle after the third bit is accepted, and `out_bit_o` then equals that third bit.
- R4: When the XOR of the first two bits of a triple is 0, that triple produces no output strobe.
- R5: `out_valid_o` is high for exactly one cycle per selected triple, and at no other time.
- R6: A cycle with `flush_i` high discards any partly collected triple, so the next accepted bit starts a new triple.
- R7: `in_ready_o` is 0 while `flush_i` is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Synchronous realign to a triple boundary |
| in_valid_i | input | 1 | Input bit is offered |
| in_bit_i | input | 1 | Input stream bit |
| in_ready_o | output | 1 | Block can take a bit this cycle |
| out_valid_o | output | 1 | One-cycle strobe marking an emitted bit |
| out_bit_o | output | 1 | Emitted bit, meaningful while the strobe is high |

## Verification
Every one of the eight possible triples is driven and checked against its expected strobe and bit. A design that XORs the wrong pair, or that emits on a zero XOR, fails here. Random streams with idle gaps go through a queue model that compares each emitted bit and the total count; a design that advances its position on idle cycles falls out of step with the model. Flush and reset are applied after the first two bits of a triple. A design that keeps the old phase would then emit from a misaligned triple, or miss an emit it owes.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int TRIPLE_LEN = 3;
  localparam int LEAD_N     = TRIPLE_LEN - 1;
  localparam int PH_W       = $clog2(TRIPLE_LEN);

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_LAST = phase_t'(TRIPLE_LEN - 1);

  // Decision on a full triple: keep the trailing bit when the leading pair differs.
  function automatic logic keep_third(input logic lead0, input logic lead1);
    return lead0 ^ lead1;
  endfunction

  // Position after one accepted beat, wrapping at the end of a triple.
  function automatic phase_t next_phase(input phase_t cur);
    return (cur == PH_LAST) ? phase_t'(0) : phase_t'(cur + 1'b1);
  endfunction
endpackage

// File: rtl/tsg_phase.sv
module tsg_phase
  import tsg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush_i,
  input  logic   adv_i,
  output phase_t phase_o,
  output logic   last_o
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) phase_q <= '0;
    else if (adv_i)        phase_q <= next_phase(phase_q);
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == PH_LAST);
endmodule

// File: rtl/tsg_hold.sv
module tsg_hold
  import tsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  phase_t            phase_i,
  input  logic              din_i,
  output logic [LEAD_N-1:0] lead_o
);
  for (genvar k = 0; k < LEAD_N; k++) begin : g_slot
    logic slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                slot_q <= 1'b0;
      else if (adv_i && (phase_i == phase_t'(k))) slot_q <= din_i;
    end
    assign lead_o[k] = slot_q;
  end
endmodule

// File: rtl/tsg_emit.sv
module tsg_emit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic din_i,
  output logic valid_o,
  output logic bit_o
);
  logic valid_q;
  logic bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= fire_i;
      if (fire_i) bit_q <= din_i;
    end
  end

  assign valid_o = valid_q;
  assign bit_o   = bit_q;
endmodule

// File: rtl/tsg_selector.sv
module tsg_selector
  import tsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic in_valid_i,
  input  logic in_bit_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic out_bit_o
);
  // Named internal events, exposed for the bound checker
  logic              accept_w;
  logic              last_w;
  logic              triple_done_w;
  logic              sel_w;
  phase_t            phase_w;
  logic [LEAD_N-1:0] lead_w;

  assign in_ready_o    = !flush_i;
  assign accept_w      = in_valid_i && in_ready_o;
  assign triple_done_w = accept_w && last_w;
  assign sel_w         = keep_third(lead_w[0], lead_w[1]);

  tsg_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .adv_i   (accept_w),
    .phase_o (phase_w),
    .last_o  (last_w)
  );

  tsg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (accept_w),
    .phase_i (phase_w),
    .din_i   (in_bit_i),
    .lead_o  (lead_w)
  );

  tsg_emit u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (triple_done_w && sel_w),
    .din_i   (in_bit_i),
    .valid_o (out_valid_o),
    .bit_o   (out_bit_o)
  );
endmodule

// File: rtl/tsg_selector_chk.sv
module tsg_selector_chk
  import tsg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   flush_i,
  input logic   in_bit_i,
  input logic   in_ready_o,
  input logic   out_valid_o,
  input logic   out_bit_o,
  input logic   accept_w,
  input logic   triple_done_w,
  input logic   sel_w,
  input phase_t phase_w
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_w && !flush_i) |=> $stable(phase_w));

  // R3
  emit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triple_done_w && sel_w) |=> (out_valid_o && (out_bit_o == $past(in_bit_i))));

  // R4
  drop_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (triple_done_w && !sel_w) |=> !out_valid_o);

  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(triple_done_w));

  // R6
  flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (phase_w == '0));

  // R7
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o == !flush_i);
endmodule

bind tsg_selector tsg_selector_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_i       (flush_i),
  .in_bit_i      (in_bit_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_bit_o     (out_bit_o),
  .accept_w      (accept_w),
  .triple_done_w (triple_done_w),
  .sel_w         (sel_w),
  .phase_w       (phase_w)
);

// File: tb/tb_tsg_selector.sv
`timescale 1ns/1ps
module tb_tsg_selector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_bit_i = 1'b0;
  logic in_ready_o, out_valid_o, out_bit_o;

  always #10 clk = ~clk;  // 50 MHz

  tsg_selector dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Table entry: {a0, a1, a2, expected strobe, expected bit}
  localparam logic [4:0] VEC [10] = '{
    5'b000_00, 5'b001_00, 5'b010_10, 5'b011_11,
    5'b100_10, 5'b101_11, 5'b110_00, 5'b111_00,
    5'b011_11, 5'b111_00
  };

  // Bench-side reference state
  int   m_phase = 0;
  logic m_a0, m_a1;
  logic exp_v = 1'b0;
  logic exp_b = 1'b0;
  logic s_v, s_b;
  bit   q[$];
  int   emitted = 0;
  int   expected_cnt = 0;

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) fail(req, what, act, expv);
  endtask

  // One cycle: check outputs produced by the previous edge, then drive new inputs.
  task automatic cyc(input logic v, input logic b, input logic f, input logic rst = 1'b0);
    @(negedge clk);
    s_v = out_valid_o;
    s_b = out_bit_o;
    checks++;
    if (s_v !== exp_v) fail("R5", "out_valid", s_v, exp_v);
    if (s_v && exp_v) begin
      checks++;
      if (s_b !== exp_b) fail("R3", "out_bit", s_b, exp_b);
    end
    if (s_v) begin
      emitted++;
      if (q.size() > 0) begin
        checks++;
        if (s_b !== q[0]) fail("R3", "queue bit", s_b, q[0]);
        void'(q.pop_front());
      end
    end
    in_valid_i = v;
    in_bit_i   = b;
    flush_i    = f;
    rst_n      = !rst;
    #1;
    if (!rst) chk("R7", "in_ready", in_ready_o, !f);
    exp_v = 1'b0;
    if (rst || f) m_phase = 0;
    else if (v) begin
      case (m_phase)
        0: m_a0 = b;
        1: m_a1 = b;
        default: if (m_a0 != m_a1) begin
          exp_v = 1'b1;
          exp_b = b;
          q.push_back(b);
          expected_cnt++;
        end
      endcase
      m_phase = (m_phase + 1) % 3;
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0);
    chk("R1", "out_valid after reset", out_valid_o, 0);
    chk("R7", "ready after reset", in_ready_o, 1);

    // Table of triples: R3, R4
    for (int i = 0; i < 10; i++) begin
      cyc(1, VEC[i][4], 0);
      cyc(1, VEC[i][3], 0);
      cyc(1, VEC[i][2], 0);
      cyc(0, 0, 0);
      chk(VEC[i][1] ? "R3" : "R4", $sformatf("table %0d strobe", i), s_v, VEC[i][1]);
      if (VEC[i][1]) chk("R3", $sformatf("table %0d bit", i), s_b, VEC[i][0]);
    end

    // R2: idle gaps inside a triple (1, gap, 0, gap, gap, 1 -> emits 1)
    cyc(1, 1, 0); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0); cyc(1, 1, 0);
    cyc(0, 0, 0);
    chk("R2", "gapped triple strobe", s_v, 1);

    // R6: flush after two bits, then triple 0,1,0 -> emits 0
    cyc(1, 1, 0); cyc(1, 1, 0); cyc(1, 1, 1);
    cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R6", "post-flush strobe", s_v, 1);
    chk("R6", "post-flush bit", s_b, 0);

    // R1: reset in mid-triple, then 1,0,1 -> emits 1
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0, 1);
    cyc(1, 1, 0); cyc(1, 0, 0); cyc(1, 1, 0); cyc(0, 0, 0);
    chk("R1", "post-reset strobe", s_v, 1);
    chk("R1", "post-reset bit", s_b, 1);

    // Random stream with gaps, checked against the queue model
    emitted = 0;
    expected_cnt = 0;
    q.delete();
    for (int i = 0; i < 600; i++) begin
      logic v = ($urandom_range(0, 3) != 0);
      cyc(v, $urandom_range(0, 1), 0);
    end
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    chk("R5", "random emit count", emitted, expected_cnt);
    chk("R3", "queue drained", q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule